// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is a small two-level logic array: three inputs feed an AND plane that forms product terms, and an OR plane combines those terms into three outputs. A compile-time parameter picks one of three structures. In the decoder style the AND plane is fixed and yields all eight minterms, so only the OR-plane connections are programmable. In the shared-term style both planes are programmable, so any output can use any product term. In the fixed-group style the AND plane is programmable and each output ORs its own group of terms.

Connection bits reach the array through a serial configuration chain. The chain shifts one bit per clock while the load enable is high, and the outputs are forced low during loading. Outside loading the array is purely combinational from inputs to outputs. A synchronous reset clears every connection bit.

Top module: `sop_array`

## Requirements
- R1: A programmable product term is the AND of the literals connected to it. Literal 2*i is input i true, and literal 2*i+1 is input i complemented. A term with no connected literals evaluates to 1.
- R2: An output is the OR of the product terms connected to it, and an output with no connected terms is 0. With cfg_en low and in_vec held, out_vec does not change.
- R3: In the decoder style (STYLE_PROM) term m is 1 exactly when in_vec equals m, taking in_vec[0] as the LSB. The chain holds only OR bits, where bit o*8+m connects minterm m to output o (24 bits).
- R4: In the shared-term style (STYLE_PLA) there are 6 terms and the chain is 54 bits. Chain bit 18+t*6+l connects literal l to term t, and chain bit o*6+t connects term t to output o.
- R5: In the fixed-group style (STYLE_PAL) there are 6 terms, and output o is the OR of terms 2*o and 2*o+1. The chain is 36 bits, and bit t*6+l connects literal l to term t.
- R6: While cfg_en is high, each clock shifts cfg_din into chain bit 0 and moves every bit up one position. The first bit sent therefore ends in the highest bit, so the AND-plane bits are sent before the OR-plane bits.
- R7: While cfg_en is high, out_vec is 0.
- R8: While cfg_en is low, cfg_din has no effect on the stored connections.
- R9: Reset clears all connection bits. After reset the outputs are 0 in the decoder and shared-term styles, and 3'b111 in the fixed-group style.
- R10: A shared-term load realises w=(a&c)|(!b&!c), x=(a&b&c)|(!b&!c) and y=a&b&c with shared terms. A decoder load realises w=a&b, x=!(a&b) and y=(a&b)^c. Here a=in_vec[0], b=in_vec[1], c=in_vec[2], and w=out_vec[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst | input | 1 | Synchronous active-high reset, clears the chain |
| cfg_en | input | 1 | Load enable: shift the chain and force outputs low |
| cfg_din | input | 1 | Serial configuration bit |
| in_vec | input | N_IN | Logic inputs (a is bit 0) |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
The bench targets the empty-connection rules. A term with no connections must read as 1 and an output with no connections as 0. A design that swapped these would turn an unused term into a dead input, or tie unconnected outputs high. The fixed-group reset value of all ones catches the same fault from the other side. The shared-term example catches any misplaced bit, whether a reversed shift order or an AND/OR field swap, because the outputs then differ on at least one of the eight input combinations. Toggling cfg_din with the enable low, and sampling the outputs during every load, exposes a chain that shifts without the enable and outputs that leak during loading.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [1:0] {
        STYLE_PROM = 2'd0,
        STYLE_PLA  = 2'd1,
        STYLE_PAL  = 2'd2
    } plane_style_e;

    typedef struct packed {
        logic shift_en;
        logic out_gate;
    } cfg_ctrl_t;

    function automatic int term_count(plane_style_e s, int n_in, int n_pt);
        return (s == STYLE_PROM) ? (1 << n_in) : n_pt;
    endfunction

    function automatic int and_cfg_bits(plane_style_e s, int n_in, int n_pt);
        return (s == STYLE_PROM) ? 0 : n_pt * 2 * n_in;
    endfunction

    function automatic int or_cfg_bits(plane_style_e s, int n_in, int n_out, int n_pt);
        return (s == STYLE_PAL) ? 0 : n_out * term_count(s, n_in, n_pt);
    endfunction

    function automatic int at_least_one(int v);
        return (v > 0) ? v : 1;
    endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    generate
        if (W == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)           q <= '0;
                else if (shift_en) q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)           q <= '0;
                else if (shift_en) q <= {q[W-2:0], din};
            end
        end
    endgenerate
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter sop_pkg::plane_style_e STYLE = sop_pkg::STYLE_PLA,
    parameter int N_IN = 3,
    parameter int N_T  = 6,
    parameter int CW   = 36
) (
    input  logic [N_IN-1:0] in_vec,
    input  logic [CW-1:0]   conn,
    output logic [N_T-1:0]  terms
);
    localparam int LW = 2 * N_IN;

    logic [LW-1:0] lits;

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            assign lits[2*i]   = in_vec[i];
            assign lits[2*i+1] = ~in_vec[i];
        end

        if (STYLE == sop_pkg::STYLE_PROM) begin : g_decoder
            logic unused_conn;
            assign unused_conn = ^{conn, lits};
            for (genvar m = 0; m < N_T; m++) begin : g_min
                assign terms[m] = (in_vec == N_IN'(m));
            end
        end else begin : g_prog
            for (genvar t = 0; t < N_T; t++) begin : g_term
                assign terms[t] = &(~conn[t*LW +: LW] | lits);
            end
        end
    endgenerate
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter sop_pkg::plane_style_e STYLE = sop_pkg::STYLE_PLA,
    parameter int N_OUT = 3,
    parameter int N_T   = 6,
    parameter int CW    = 18
) (
    input  logic [N_T-1:0]   terms,
    input  logic [CW-1:0]    conn,
    output logic [N_OUT-1:0] sums
);
    localparam int GRP = N_T / N_OUT;

    generate
        if (STYLE == sop_pkg::STYLE_PAL) begin : g_fixed
            logic unused_conn;
            assign unused_conn = ^conn;
            for (genvar o = 0; o < N_OUT; o++) begin : g_out
                assign sums[o] = |terms[o*GRP +: GRP];
            end
        end else begin : g_prog
            for (genvar o = 0; o < N_OUT; o++) begin : g_out
                assign sums[o] = |(terms & conn[o*N_T +: N_T]);
            end
        end
    endgenerate
endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter sop_pkg::plane_style_e STYLE = sop_pkg::STYLE_PLA,
    parameter int N_IN  = 3,
    parameter int N_OUT = 3,
    parameter int N_PT  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec
);
    localparam int N_T   = sop_pkg::term_count(STYLE, N_IN, N_PT);
    localparam int AND_B = sop_pkg::and_cfg_bits(STYLE, N_IN, N_PT);
    localparam int OR_B  = sop_pkg::or_cfg_bits(STYLE, N_IN, N_OUT, N_PT);
    localparam int CFG_W = AND_B + OR_B;
    localparam int AND_W = sop_pkg::at_least_one(AND_B);
    localparam int OR_W  = sop_pkg::at_least_one(OR_B);

    sop_pkg::cfg_ctrl_t ctrl;
    logic [CFG_W-1:0]   cfg_q;
    logic [AND_W-1:0]   and_conn;
    logic [OR_W-1:0]    or_conn;
    logic [N_T-1:0]     terms;
    logic [N_OUT-1:0]   sums;

    assign ctrl.shift_en = cfg_en;
    assign ctrl.out_gate = ~cfg_en;

    sop_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (ctrl.shift_en),
        .din      (cfg_din),
        .q        (cfg_q)
    );

    generate
        if (AND_B > 0) begin : g_and_cfg
            assign and_conn = cfg_q[CFG_W-1 -: AND_W];
        end else begin : g_and_none
            assign and_conn = '0;
        end
        if (OR_B > 0) begin : g_or_cfg
            assign or_conn = cfg_q[OR_W-1:0];
        end else begin : g_or_none
            assign or_conn = '0;
        end
    endgenerate

    sop_and_plane #(.STYLE(STYLE), .N_IN(N_IN), .N_T(N_T), .CW(AND_W)) u_and (
        .in_vec (in_vec),
        .conn   (and_conn),
        .terms  (terms)
    );

    sop_or_plane #(.STYLE(STYLE), .N_OUT(N_OUT), .N_T(N_T), .CW(OR_W)) u_or (
        .terms (terms),
        .conn  (or_conn),
        .sums  (sums)
    );

    assign out_vec = ctrl.out_gate ? sums : '0;
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int N_IN    = 3,
    parameter int N_OUT   = 3,
    parameter int N_T     = 6,
    parameter int CFG_W   = 54,
    parameter bit IS_PROM = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic             cfg_din,
    input logic [N_IN-1:0]  in_vec,
    input logic [N_OUT-1:0] out_vec,
    input logic [CFG_W-1:0] cfg_q,
    input logic [N_T-1:0]   terms
);
    // R7
    a_r7_out_zero_loading: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> out_vec == '0);

    // R8
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_q));

    // R6
    a_r6_shift_capture: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_q[0] == $past(cfg_din));

    // R2
    a_r2_comb_stable: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && $past(!cfg_en) && $stable(in_vec)) |-> $stable(out_vec));

    generate
        if (CFG_W > 1) begin : g_move
            // R6
            a_r6_shift_move: assert property (@(posedge clk) disable iff (rst)
                cfg_en |=> cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-2:0]));
        end
        if (IS_PROM) begin : g_dec
            // R3
            a_r3_one_minterm: assert property (@(posedge clk) disable iff (rst)
                $countones(terms) == 1);
        end
    endgenerate
endmodule

bind sop_array sop_array_chk #(
    .N_IN    (N_IN),
    .N_OUT   (N_OUT),
    .N_T     (N_T),
    .CFG_W   (CFG_W),
    .IS_PROM (STYLE == sop_pkg::STYLE_PROM)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .in_vec  (in_vec),
    .out_vec (out_vec),
    .cfg_q   (cfg_q),
    .terms   (terms)
);

// File: tb/tb_sop_array.sv
`timescale 1ns/1ps
module tb_sop_array;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_pla = 1'b0, en_prom = 1'b0, en_pal = 1'b0;
    logic       cfg_din = 1'b0;
    logic [2:0] in_vec = 3'd0;
    logic [2:0] out_pla, out_prom, out_pal;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    sop_array #(.STYLE(sop_pkg::STYLE_PLA)) dut (
        .clk(clk), .rst(rst), .cfg_en(en_pla), .cfg_din(cfg_din),
        .in_vec(in_vec), .out_vec(out_pla));
    sop_array #(.STYLE(sop_pkg::STYLE_PROM)) dut_prom (
        .clk(clk), .rst(rst), .cfg_en(en_prom), .cfg_din(cfg_din),
        .in_vec(in_vec), .out_vec(out_prom));
    sop_array #(.STYLE(sop_pkg::STYLE_PAL)) dut_pal (
        .clk(clk), .rst(rst), .cfg_en(en_pal), .cfg_din(cfg_din),
        .in_vec(in_vec), .out_vec(out_pal));

    // sel: 0 = shared-term, 1 = decoder, 2 = fixed-group
    function automatic logic [2:0] get_out(input int sel);
        if (sel == 0) return out_pla;
        if (sel == 1) return out_prom;
        return out_pal;
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s in=%b actual=%b expected=%b", req, in_vec, act, exp);
        end
    endtask

    task automatic set_en(input int sel, input logic v);
        if (sel == 0) en_pla = v;
        else if (sel == 1) en_prom = v;
        else en_pal = v;
    endtask

    // R6 MSB first; R7 outputs low while loading
    task automatic load(input int sel, input logic [63:0] v, input int len);
        in_vec = 3'b101;
        for (int k = len - 1; k >= 0; k--) begin
            @(negedge clk);
            set_en(sel, 1'b1);
            cfg_din = v[k];
            #1;
            if (k % 9 == 0) check("R7", get_out(sel), 3'b000);
        end
        @(negedge clk);
        set_en(sel, 1'b0);
        cfg_din = 1'b0;
        #1;
    endtask

    function automatic logic [2:0] ref_pla_ex(input logic [2:0] i);
        logic a, b, c;
        {c, b, a} = i;
        return {a & b & c, (a & b & c) | (!b & !c), (a & c) | (!b & !c)};
    endfunction

    task automatic sweep(input string req, input int sel, input int kind);
        for (int m = 0; m < 8; m++) begin
            logic a, b, c;
            logic [2:0] e;
            in_vec = 3'(m);
            {c, b, a} = 3'(m);
            case (kind)
                0: e = ref_pla_ex(3'(m));
                1: e = {(a & b) ^ c, !(a & b), a & b};
                2: e = {(b & !c) | (!a & c), a & b, a | !c};
                default: e = 3'b001;
            endcase
            #1;
            check(req, get_out(sel), e);
        end
    endtask

    task automatic t_reset;
        for (int m = 0; m < 8; m++) begin
            in_vec = 3'(m);
            #1;
            check("R9", out_pla, 3'b000);
            check("R9", out_prom, 3'b000);
            check("R9", out_pal, 3'b111);
        end
    endtask

    // R4 layout: and bit 18+t*6+l, or bit o*6+t; literals a=0 !a=1 b=2 !b=3 c=4 !c=5
    task automatic t_pla_example;
        logic [63:0] v = '0;
        v[18 + 0*6 + 0] = 1'b1; v[18 + 0*6 + 4] = 1'b1;
        v[18 + 1*6 + 3] = 1'b1; v[18 + 1*6 + 5] = 1'b1;
        v[18 + 2*6 + 0] = 1'b1; v[18 + 2*6 + 2] = 1'b1; v[18 + 2*6 + 4] = 1'b1;
        v[0*6 + 0] = 1'b1; v[0*6 + 1] = 1'b1;
        v[1*6 + 2] = 1'b1; v[1*6 + 1] = 1'b1;
        v[2*6 + 2] = 1'b1;
        load(0, v, 54);
        sweep("R10_R4", 0, 0);
    endtask

    task automatic t_ignore_din;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cfg_din = ~cfg_din;
        end
        @(negedge clk);
        cfg_din = 1'b0;
        sweep("R8", 0, 0);
    endtask

    task automatic t_prom_example;
        logic [63:0] v = '0;
        for (int m = 0; m < 8; m++) begin
            logic [2:0] mm;
            mm = 3'(m);
            v[0*8 + m] = mm[0] & mm[1];
            v[1*8 + m] = !(mm[0] & mm[1]);
            v[2*8 + m] = (mm[0] & mm[1]) ^ mm[2];
        end
        load(1, v, 24);
        sweep("R10_R3", 1, 1);
    endtask

    task automatic t_pal;
        logic [63:0] v = '0;
        v[0*6 + 0] = 1'b1;
        v[1*6 + 5] = 1'b1;
        v[2*6 + 0] = 1'b1; v[2*6 + 2] = 1'b1;
        v[3*6 + 0] = 1'b1; v[3*6 + 1] = 1'b1;
        v[4*6 + 2] = 1'b1; v[4*6 + 5] = 1'b1;
        v[5*6 + 1] = 1'b1; v[5*6 + 4] = 1'b1;
        load(2, v, 36);
        sweep("R5", 2, 2);
    endtask

    // R1 empty term is 1, R2 empty output is 0
    task automatic t_empty;
        logic [63:0] v = '0;
        v[18 + 1*6 + 0] = 1'b1; v[18 + 1*6 + 1] = 1'b1;
        v[0*6 + 0] = 1'b1;
        v[2*6 + 1] = 1'b1;
        load(0, v, 54);
        sweep("R1_R2", 0, 3);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pla_example();
        t_ignore_din();
        t_prom_example();
        t_pal();
        t_empty();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule